// File: doc/BRIEF.md
# Stochastic Rounding Float Narrower

This block narrows IEEE single-precision values into an 18-bit training float made of a sign bit, an 8-bit exponent with the same bias as the source, and a 9-bit mantissa (a parameter, so a wider variant only changes `MANT_W`). It sits behind an arithmetic unit that produces full-width results. One value can enter on every clock. The narrowed result appears two cycles later, with a matching valid flag.

A run-time control input selects how the 14 discarded mantissa bits are handled. When it is low, they are dropped, which rounds toward zero. When it is high, an inexact value is rounded up (away from zero by one unit in the last place) on about one conversion in five. The choice comes from an internal 16-bit LFSR, compared against a small constant. This costs an 8-bit compare rather than an exact probability calculation.

Each input is sorted into one of four value classes: zero, normal, infinite and not-a-number. The output stage handles each class separately, with a `unique case`. In the zero class, which includes denormals, the result is flushed to a signed zero. In the normal class, the result is truncated or rounded up. A carry out of the mantissa moves into the exponent, and a result that would reach the all-ones exponent saturates instead. In the infinite class, the result is a signed infinity. In the not-a-number class, the result is a NaN that keeps a nonzero mantissa.

Top module: `srfn_narrower`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `out_valid` is 0 and `out_value` is all zeros.
- R2: `out_valid` equals the value `in_valid` had two clock edges earlier, so one result can leave on every cycle.
- R3: With `stoch_en` low, a normal input (exponent 1..254) produces the following, with no rounding: sign = `in_value[31]`, exponent = `in_value[30:23]`, mantissa = `in_value[22:14]`.
- R4: A normal input whose discarded bits `in_value[13:0]` are all zero produces the truncated result of R3 in either mode.
- R5: The LFSR is 16 bits wide and is loaded with 16'hACE1 by reset. On every cycle with `in_valid` high it shifts left, and bit 0 takes the XOR of bits 15, 13, 12 and 10. On cycles with `in_valid` low it holds.
- R6: With `stoch_en` high, an inexact normal input is rounded up by one mantissa LSB exactly when the low 8 bits of the LFSR, as they were on the cycle the input was accepted, are below 51. Otherwise it is truncated. Over many inexact inputs, the fraction rounded up lies between 15% and 25%.
- R7: When a round-up meets an all-ones mantissa, the result has mantissa zero and an exponent one higher.
- R8: A round-up that would produce exponent 255 saturates instead: the exponent becomes 254, the mantissa all ones, and the sign is kept.
- R9: An input with exponent 255 and mantissa zero produces exponent 255, mantissa zero and the same sign, in both modes.
- R10: An input with exponent 255 and a nonzero mantissa produces the following, never rounded: exponent 255, mantissa MSB 1, lower mantissa bits = `in_value[21:14]`, and the same sign.
- R11: An input with exponent 0 (zero or denormal) produces a signed zero, `{in_value[31], 17'b0}`, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input value present; advances the LFSR |
| in_value | input | 32 | IEEE single-precision source value |
| stoch_en | input | 1 | 1 = pseudo-random round-up, 0 = truncate |
| out_valid | output | 1 | Result present |
| out_value | output | 18 | Narrowed value {sign, exponent, mantissa} |

## Verification
The bound checker delays each input by two cycles and checks the following on every cycle: the valid timing, sign preservation, the truncated result in the plain and exact cases, and the output for each special class. It also checks that no normal input ever produces the all-ones exponent, that a stochastic result is either the truncated value or one step above it, and that the LFSR moves only on accepted inputs. Only the bench's sweeps can show that each round-up occurs on exactly the cycle the LFSR sequence predicts, that the round-up rate comes out near one in five, and that the carry and saturation corners are actually reached.

// File: rtl/srfn_pkg.sv
package srfn_pkg;

    localparam int SRC_W      = 32;
    localparam int SRC_EXP_W  = 8;
    localparam int SRC_MANT_W = 23;

    // value class carried from the decode stage to the pack stage
    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NORM = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } val_class_e;

    typedef struct packed {
        val_class_e cls;
        logic       sign;
        logic       bump;
    } stage_ctl_t;

endpackage

// File: rtl/srfn_lfsr.sv
module srfn_lfsr #(
    parameter int          W    = 16,
    parameter logic [15:0] SEED = 16'hACE1,
    parameter logic [15:0] TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] state
);

    logic [W-1:0] state_q;
    logic         fb;

    assign fb    = ^(state_q & TAPS[W-1:0]);
    assign state = state_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED[W-1:0];
        end else if (step) begin
            state_q <= {state_q[W-2:0], fb};
        end
    end

endmodule

// File: rtl/srfn_decode.sv
module srfn_decode
    import srfn_pkg::*;
#(
    parameter int MANT_W    = 9,
    parameter int RND_W     = 8,
    parameter int RU_THRESH = 51,
    localparam int EXP_W    = SRC_EXP_W,
    localparam int MAG_W    = EXP_W + MANT_W,
    localparam int DROP_W   = SRC_MANT_W - MANT_W
) (
    input  logic [SRC_W-1:0] value,
    input  logic             stoch,
    input  logic [RND_W-1:0] rnd,
    output stage_ctl_t       ctl,
    output logic [MAG_W-1:0] mag
);

    logic [EXP_W-1:0]      exp_f;
    logic [SRC_MANT_W-1:0] man_f;
    logic                  inexact;
    logic                  pick_up;

    assign exp_f = value[SRC_W-2 -: EXP_W];
    assign man_f = value[SRC_MANT_W-1:0];
    assign mag   = {exp_f, man_f[SRC_MANT_W-1 -: MANT_W]};

    generate
        if (DROP_W > 0) begin : g_drop
            assign inexact = |man_f[DROP_W-1:0];
        end else begin : g_nodrop
            assign inexact = 1'b0;
        end
    endgenerate

    assign pick_up = (rnd < RND_W'(RU_THRESH));

    always_comb begin
        ctl.sign = value[SRC_W-1];
        ctl.bump = 1'b0;
        if (exp_f == '0) begin
            ctl.cls = CLS_ZERO;
        end else if (exp_f == '1) begin
            ctl.cls = (man_f == '0) ? CLS_INF : CLS_NAN;
        end else begin
            ctl.cls  = CLS_NORM;
            ctl.bump = stoch & inexact & pick_up;
        end
    end

endmodule

// File: rtl/srfn_pack.sv
module srfn_pack
    import srfn_pkg::*;
#(
    parameter int MANT_W  = 9,
    localparam int EXP_W  = SRC_EXP_W,
    localparam int MAG_W  = EXP_W + MANT_W,
    localparam int OUT_W  = 1 + MAG_W
) (
    input  stage_ctl_t       ctl,
    input  logic [MAG_W-1:0] mag,
    output logic [OUT_W-1:0] result
);

    localparam logic [MAG_W-1:0] MAX_FIN = {{(EXP_W-1){1'b1}}, 1'b0, {MANT_W{1'b1}}};

    logic [MAG_W-1:0] stepped;
    logic [MAG_W-1:0] nan_mag;

    // a carry out of the mantissa lands in the exponent field by itself
    assign stepped = mag + MAG_W'(ctl.bump);
    assign nan_mag = {{EXP_W{1'b1}}, 1'b1, mag[MANT_W-2:0]};

    always_comb begin
        unique case (ctl.cls)
            CLS_ZERO: result = {ctl.sign, {MAG_W{1'b0}}};
            CLS_INF:  result = {ctl.sign, {EXP_W{1'b1}}, {MANT_W{1'b0}}};
            CLS_NAN:  result = {ctl.sign, nan_mag};
            CLS_NORM: begin
                if (stepped[MAG_W-1 -: EXP_W] == '1) begin
                    result = {ctl.sign, MAX_FIN};
                end else begin
                    result = {ctl.sign, stepped};
                end
            end
            default:  result = '0;
        endcase
    end

endmodule

// File: rtl/srfn_narrower.sv
module srfn_narrower
    import srfn_pkg::*;
#(
    parameter int          MANT_W     = 9,
    parameter int          LFSR_W     = 16,
    parameter logic [15:0] LFSR_SEED  = 16'hACE1,
    parameter logic [15:0] LFSR_TAPS  = 16'hB400,
    parameter int          RND_W      = 8,
    parameter int          RU_THRESH  = 51,
    localparam int         MAG_W      = SRC_EXP_W + MANT_W,
    localparam int         OUT_W      = 1 + MAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SRC_W-1:0] in_value,
    input  logic             stoch_en,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_value
);

    logic [LFSR_W-1:0] lfsr_state;
    stage_ctl_t        dec_ctl;
    logic [MAG_W-1:0]  dec_mag;
    logic              s1_vld;
    stage_ctl_t        s1_ctl;
    logic [MAG_W-1:0]  s1_mag;
    logic [OUT_W-1:0]  packed_val;

    srfn_lfsr #(
        .W    (LFSR_W),
        .SEED (LFSR_SEED),
        .TAPS (LFSR_TAPS)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (in_valid),
        .state (lfsr_state)
    );

    srfn_decode #(
        .MANT_W    (MANT_W),
        .RND_W     (RND_W),
        .RU_THRESH (RU_THRESH)
    ) u_decode (
        .value (in_value),
        .stoch (stoch_en),
        .rnd   (lfsr_state[RND_W-1:0]),
        .ctl   (dec_ctl),
        .mag   (dec_mag)
    );

    // stage 1: decoded class, magnitude and rounding choice
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_ctl <= '{cls: CLS_ZERO, sign: 1'b0, bump: 1'b0};
            s1_mag <= '0;
        end else begin
            s1_vld <= in_valid;
            s1_ctl <= dec_ctl;
            s1_mag <= dec_mag;
        end
    end

    srfn_pack #(
        .MANT_W (MANT_W)
    ) u_pack (
        .ctl    (s1_ctl),
        .mag    (s1_mag),
        .result (packed_val)
    );

    // stage 2: output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_value <= '0;
        end else begin
            out_valid <= s1_vld;
            out_value <= packed_val;
        end
    end

endmodule

// File: rtl/srfn_checker.sv
module srfn_checker #(
    parameter int MANT_W  = 9,
    parameter int LFSR_W  = 16,
    localparam int MAG_W  = 8 + MANT_W,
    localparam int OUT_W  = 1 + MAG_W,
    localparam int DROP_W = 23 - MANT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [31:0]       in_value,
    input logic              stoch_en,
    input logic              out_valid,
    input logic [OUT_W-1:0]  out_value,
    input logic [LFSR_W-1:0] lfsr_q
);

    logic [1:0]  cyc;
    logic        v1, v2, m1, m2;
    logic [31:0] x1, x2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc <= '0;
            v1 <= 1'b0; v2 <= 1'b0;
            m1 <= 1'b0; m2 <= 1'b0;
            x1 <= '0;   x2 <= '0;
        end else begin
            if (cyc != 2'd2) cyc <= cyc + 2'd1;
            v1 <= in_valid; v2 <= v1;
            m1 <= stoch_en; m2 <= m1;
            x1 <= in_value; x2 <= x1;
        end
    end

    logic [7:0]       e2;
    logic [22:0]      f2;
    logic             norm2, exact2;
    logic [MAG_W-1:0] trunc2;
    logic [MAG_W-1:0] out_mag;

    assign e2      = x2[30:23];
    assign f2      = x2[22:0];
    assign norm2   = (e2 != 8'h00) && (e2 != 8'hFF);
    assign exact2  = (f2[DROP_W-1:0] == '0);
    assign trunc2  = {e2, f2[22 -: MANT_W]};
    assign out_mag = out_value[MAG_W-1:0];

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd2) |-> (out_valid == v2)); // R2

    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cyc == 2'd2) |-> (out_value[OUT_W-1] == x2[31])); // R3

    AST_TRUNC_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cyc == 2'd2 && !m2 && norm2) |-> (out_mag == trunc2)); // R3

    AST_EXACT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cyc == 2'd2 && norm2 && exact2) |-> (out_mag == trunc2)); // R4

    AST_LFSR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cyc != 2'd0) |=> (lfsr_q != $past(lfsr_q))); // R5

    AST_LFSR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && cyc != 2'd0) |=> $stable(lfsr_q)); // R5

    AST_ROUND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cyc == 2'd2 && m2 && norm2)
        |-> (out_mag == trunc2 || out_mag == trunc2 + MAG_W'(1)
             || out_mag == {8'hFE, {MANT_W{1'b1}}})); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cyc == 2'd2 && norm2) |-> (out_mag[MAG_W-1 -: 8] != 8'hFF)); // R8

    AST_INF_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cyc == 2'd2 && e2 == 8'hFF && f2 == '0)
        |-> (out_value == {x2[31], 8'hFF, {MANT_W{1'b0}}})); // R9

    AST_NAN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cyc == 2'd2 && e2 == 8'hFF && f2 != '0)
        |-> (out_mag[MAG_W-1 -: 8] == 8'hFF && out_mag[MANT_W-1:0] != '0)); // R10

    AST_ZERO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cyc == 2'd2 && e2 == 8'h00) |-> (out_mag == '0)); // R11

endmodule

bind srfn_narrower srfn_checker #(
    .MANT_W (MANT_W),
    .LFSR_W (LFSR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_value  (in_value),
    .stoch_en  (stoch_en),
    .out_valid (out_valid),
    .out_value (out_value),
    .lfsr_q    (lfsr_state)
);

// File: tb/srfn_narrower_bench.sv
`timescale 1ns/1ps
module srfn_narrower_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_value;
    logic        stoch_en;
    logic        out_valid;
    logic [17:0] out_value;

    always #2 clk = ~clk;

    srfn_narrower u_srfn_narrower (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_value  (in_value),
        .stoch_en  (stoch_en),
        .out_valid (out_valid),
        .out_value (out_value)
    );

    int checks = 0;
    int errors = 0;
    int hit_r7 = 0;
    int hit_r8 = 0;
    int stoch_n = 0;
    int stoch_up = 0;

    logic [15:0] lfsr_m;
    logic        pv [2];
    logic [17:0] pe [2];
    string       pt [2];

    function automatic logic [17:0] model(input logic [31:0] x, input logic bump);
        logic [7:0]  e;
        logic [22:0] f;
        logic [16:0] mag;
        e = x[30:23];
        f = x[22:0];
        if (e == 8'h00) return {x[31], 17'd0};
        if (e == 8'hFF) begin
            if (f == 23'd0) return {x[31], 8'hFF, 9'd0};
            return {x[31], 8'hFF, 1'b1, f[21:14]};
        end
        mag = {e, f[22:14]};
        if (bump && f[13:0] != 14'd0) mag = mag + 17'd1;
        if (mag[16:9] == 8'hFF) mag = {8'hFE, 9'h1FF};
        return {x[31], mag};
    endfunction

    task automatic step(input logic v, input logic [31:0] x, input logic m);
        logic       bump;
        logic [7:0] e;
        logic       inexact;
        @(negedge clk);
        checks++;
        if (out_valid !== pv[1]) begin
            errors++;
            $display("FAIL R2 out_valid actual %b expected %b", out_valid, pv[1]);
        end
        if (pv[1]) begin
            checks++;
            if (out_value !== pe[1]) begin
                errors++;
                $display("FAIL %s out_value actual %h expected %h", pt[1], out_value, pe[1]);
            end
        end
        pv[1] = pv[0]; pe[1] = pe[0]; pt[1] = pt[0];
        in_valid = v; in_value = x; stoch_en = m;
        pv[0] = v;
        if (v) begin
            e       = x[30:23];
            inexact = (x[13:0] != 14'd0);
            bump    = m && (lfsr_m[7:0] < 8'd51);
            pe[0]   = model(x, bump);
            if (e == 8'h00)                           pt[0] = "R11";
            else if (e == 8'hFF)                      pt[0] = (x[22:0] == 0) ? "R9" : "R10";
            else if (!inexact)                        pt[0] = "R4";
            else if (!m)                              pt[0] = "R3";
            else if (bump && x[22:14] == 9'h1FF && e == 8'hFE) begin pt[0] = "R8"; hit_r8++; end
            else if (bump && x[22:14] == 9'h1FF)      begin pt[0] = "R7"; hit_r7++; end
            else                                      pt[0] = "R5/R6";
            if (m && inexact && e != 8'h00 && e != 8'hFF) begin
                stoch_n++;
                if (bump) stoch_up++;
            end
            lfsr_m = {lfsr_m[14:0], lfsr_m[15] ^ lfsr_m[13] ^ lfsr_m[12] ^ lfsr_m[10]};
        end
    endtask

    function automatic logic [22:0] mant_pick(input int k, input int e);
        case (k)
            0: return 23'h000000;
            1: return 23'h7FFFFF;
            2: return 23'h7FC000;
            3: return 23'h7FC001;
            4: return 23'h000001;
            5: return 23'h2AAAAA;
            6: return 23'h400000;
            default: return 23'((e * 32'h1357) ^ 32'h0A5A5);
        endcase
    endfunction

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_value = '0; stoch_en = 1'b0;
        lfsr_m = 16'hACE1;
        pv[0] = 1'b0; pv[1] = 1'b0; pe[0] = '0; pe[1] = '0; pt[0] = ""; pt[1] = "";
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0 || out_value !== 18'd0) begin
                errors++;
                $display("FAIL R1 reset outputs actual %b/%h expected 0/00000", out_valid, out_value);
            end
        end
        rst_n = 1'b1;
        step(1'b0, 32'd0, 1'b0);
        checks++;
        if (out_valid !== 1'b0 || out_value !== 18'd0) begin
            errors++;
            $display("FAIL R1 after reset actual %b/%h expected 0/00000", out_valid, out_value);
        end

        // sweep every exponent, several mantissa shapes, both modes, idle gaps
        for (int m = 0; m < 2; m++) begin
            for (int e = 0; e < 256; e++) begin
                for (int k = 0; k < 8; k++) begin
                    if (((e * 8 + k) % 7) == 3) step(1'b0, $urandom, 1'b1);
                    step(1'b1, {1'(k + e), 8'(e), mant_pick(k, e)}, 1'(m));
                end
            end
        end

        // mixed modes on inexact normals, for the rate and carry cases
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[30:23] == 8'h00 || r[30:23] == 8'hFF) r[30:23] = 8'h80;
            if (i % 4 == 0) r[22:14] = 9'h1FF;
            r[0] = 1'b1;
            step(1'b1, r, 1'(i % 5 != 0));
        end

        // saturation corner
        for (int i = 0; i < 80; i++) step(1'b1, {1'(i), 8'hFE, 23'h7FFFFF}, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b0, 32'd0, 1'b0);

        checks++;
        if (hit_r7 == 0) begin
            errors++;
            $display("FAIL R7 carry round-ups actual %0d expected >0", hit_r7);
        end
        checks++;
        if (hit_r8 == 0) begin
            errors++;
            $display("FAIL R8 saturating round-ups actual %0d expected >0", hit_r8);
        end
        checks++;
        if (stoch_up * 100 < stoch_n * 15 || stoch_up * 100 > stoch_n * 25) begin
            errors++;
            $display("FAIL R6 round-up count actual %0d expected 15..25%% of %0d", stoch_up, stoch_n);
        end
        summary();
        $finish;
    end

endmodule